// File: doc/BRIEF.md
# Reload-Timer PWM Generator

A memory-mapped timer that turns a free-running up-counter into a pulse-width modulated output. The counter counts up one step per clock while the timer runs. When it passes its all-ones value, it restarts from a programmable reload value. The output is set when the counter equals a programmable match value, and it is cleared when the counter wraps. The reload value therefore sets the period and the match value sets the duty cycle.

Software reaches four registers through a single-cycle register bus inside a 4 KB window: control, counter, reload and match. Read data is combinational from the address. A write lands on the clock edge that samples the request.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset, all four registers read zero and `pwm_o` is low.
- R2: Registers sit at these offsets and read back what was written: control 0x024, counter 0x028, reload 0x02C and match 0x038. In the control register, bit 0 is run and bit 1 is compare enable. Its other bits read zero.
- R3: With run set, the counter rises by one on each clock. With run clear, it holds its value.
- R4: When the counter is at all-ones while running, the next clock loads it with the reload value.
- R5: With run and compare enable set, `pwm_o` rises on the clock after the counter equals the match value.
- R6: `pwm_o` falls on the clock after the counter wraps. A wrap and a match in the same cycle (match = all-ones) leave `pwm_o` low.
- R7: In steady state the period is 2^32 − reload cycles, and `pwm_o` is high for 0xFFFFFFFF − match cycles of each period. A match equal to reload gives the longest high time, period − 1.
- R8: While compare enable is clear, `pwm_o` is low on the next clock and stays low.
- R9: A match value below the reload value never hits, so `pwm_o` stays low.
- R10: A bus write to the counter takes effect on that clock edge, even while running, in place of the increment.
- R11: Reads of any other offset return zero. Writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset in the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
The waveform is measured over whole periods for several settings:
- a mid-period match;
- a match equal to reload, for the longest high time;
- a match at all-ones, where the wrap and the match collide;
- a match below reload, which never hits;
- a longer period.

Together these separate an off-by-one in the set or clear edge from a wrong reload or compare width. An exact cycle-by-cycle run through one match and one wrap pins the latency of both edges. Counter writes made while the timer is running show that the write wins over the increment. Accesses to unmapped offsets show that no register aliases onto them.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_RELOAD = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_MATCH = 12'h038;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_CMP_BIT = 1;

  typedef struct packed {
    logic cmp_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rpwm_regs.sv
module rpwm_regs
  import rpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  match_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o
);
  logic sel_ctrl, sel_cnt, sel_rld, sel_mat, hit;
  logic wr;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, match_q;

  assign sel_ctrl = (addr_i == OFF_CTRL);
  assign sel_cnt  = (addr_i == OFF_COUNT);
  assign sel_rld  = (addr_i == OFF_RELOAD);
  assign sel_mat  = (addr_i == OFF_MATCH);
  assign hit      = sel_ctrl | sel_cnt | sel_rld | sel_mat;
  assign wr       = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      match_q  <= '0;
    end else if (wr) begin
      if (sel_ctrl) begin
        ctrl_q.run    <= wdata_i[CTRL_RUN_BIT];
        ctrl_q.cmp_en <= wdata_i[CTRL_CMP_BIT];
      end
      if (sel_rld) reload_q <= wdata_i[CNT_W-1:0];
      if (sel_mat) match_q  <= wdata_i[CNT_W-1:0];
    end
  end

  assign cnt_wr_o    = wr & sel_cnt;
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_ctrl: begin
        rdata_o[CTRL_RUN_BIT] = ctrl_q.run;
        rdata_o[CTRL_CMP_BIT] = ctrl_q.cmp_en;
      end
      sel_cnt: rdata_o = DATA_W'(cnt_i);
      sel_rld: rdata_o = DATA_W'(reload_q);
      sel_mat: rdata_o = DATA_W'(match_q);
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign match_o  = match_q;

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !hit) |=> ($stable(ctrl_q) && $stable(reload_q) && $stable(match_q)));
  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));
endmodule

// File: rtl/rpwm_counter.sv
module rpwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign wrap_o = run_i & ~wr_i & at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (run_i)  cnt_q <= at_max ? reload_i : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_i && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_i) |=> $stable(cnt_q));
  // R4
  cnt_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(reload_i)));
  // R10
  cnt_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/rpwm_out.sv
module rpwm_out #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             wrap_i,
  output logic             pwm_o
);
  logic pwm_q, hit;

  assign hit = run_i & (cnt_i == match_i);

  // clear on wrap wins over set on match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pwm_q <= 1'b0;
    else if (!cmp_en_i) pwm_q <= 1'b0;
    else if (wrap_i)    pwm_q <= 1'b0;
    else if (hit)       pwm_q <= 1'b1;
  end

  assign pwm_o = pwm_q;

  // R8
  cmp_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> !pwm_q);
  // R6
  wrap_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !pwm_q);
  // R5
  match_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && hit && !wrap_i) |=> pwm_q);
  // R5
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> $past(hit));
endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import rpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [11:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        pwm_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, match, cnt, cnt_wdata;
  logic             cnt_wr, wrap;

  rpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (bus_req_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .cnt_i       (cnt),
    .ctrl_o      (ctrl),
    .reload_o    (reload),
    .match_o     (match),
    .cnt_wr_o    (cnt_wr),
    .cnt_wdata_o (cnt_wdata)
  );

  rpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.run),
    .wr_i     (cnt_wr),
    .wdata_i  (cnt_wdata),
    .reload_i (reload),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  rpwm_out #(.CNT_W(CNT_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.run),
    .cmp_en_i (ctrl.cmp_en),
    .cnt_i    (cnt),
    .match_i  (match),
    .wrap_i   (wrap),
    .pwm_o    (pwm_o)
  );
endmodule

// File: tb/reload_pwm_timer_tb.sv
`timescale 1ns/1ps
module reload_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [11:0] A_CTRL = 12'h024, A_CNT = 12'h028,
                          A_RLD = 12'h02C, A_MAT = 12'h038;

  always #2.5 clk = ~clk;

  reload_pwm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp_v);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1; req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; req = 1'b1; we = 1'b0;
    #0.5 d = rdata;
    req = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic high_cycles(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic setup(input logic [31:0] rld, input logic [31:0] mat);
    wr(A_CTRL, 0);
    wr(A_RLD, rld);
    wr(A_MAT, mat);
    wr(A_CNT, rld);
    wr(A_CTRL, 3);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_CNT, d);  chk("R1 count", d, 0);
    rd(A_RLD, d);  chk("R1 reload", d, 0);
    rd(A_MAT, d);  chk("R1 match", d, 0);
    chk("R1 pwm", {31'b0, pwm}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_RLD, 32'hA5A5_1234); rd(A_RLD, d); chk("R2 reload", d, 32'hA5A5_1234);
    wr(A_MAT, 32'h5A5A_8765); rd(A_MAT, d); chk("R2 match", d, 32'h5A5A_8765);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, d); chk("R2 ctrl bits", d, 32'h2);
    wr(A_CTRL, 0);
    wr(A_CNT, 32'h0000_0777); rd(A_CNT, d); chk("R2 count", d, 32'h777);
  endtask

  task automatic t_count;
    logic [31:0] a, b;
    wr(A_CTRL, 0);
    wr(A_CNT, 100);
    edges(5); rd(A_CNT, a); chk("R3 hold while stopped", a, 100);
    wr(A_CTRL, 1);
    rd(A_CNT, a); chk("R3 first step", a, 100);
    edges(7); rd(A_CNT, b); chk("R3 increment", b, 107);
    wr(A_CNT, 32'h0000_5000); rd(A_CNT, a); chk("R10 write while running", a, 32'h5000);
    edges(1); rd(A_CNT, a); chk("R10 resumes", a, 32'h5001);
    wr(A_CTRL, 0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(A_CTRL, 0);
    wr(A_RLD, 32'hFFFF_FFF0);
    wr(A_MAT, 32'hFFFF_FFF4);
    wr(A_CNT, 32'hFFFF_FFF2);
    wr(A_CTRL, 3);
    edges(2); chk("R5 before match", {31'b0, pwm}, 0);
    edges(1); chk("R5 set after match", {31'b0, pwm}, 1);
    edges(10); rd(A_CNT, d); chk("R4 at max", d, 32'hFFFF_FFFF);
    chk("R6 high at max", {31'b0, pwm}, 1);
    edges(1); rd(A_CNT, d); chk("R4 reloaded", d, 32'hFFFF_FFF0);
    chk("R6 cleared on wrap", {31'b0, pwm}, 0);
  endtask

  task automatic t_duty(input string tag, input logic [31:0] rld, input logic [31:0] mat,
                        input int period, input int exp_hi);
    int hi;
    setup(rld, mat);
    edges(2 * period + 3);
    high_cycles(period, hi); chk(tag, hi, exp_hi);
    high_cycles(period, hi); chk(tag, hi, exp_hi);
  endtask

  task automatic t_cmp_off;
    int hi;
    setup(32'hFFFF_FFF0, 32'hFFFF_FFF8);
    edges(20);
    wr(A_CTRL, 1);
    high_cycles(32, hi); chk("R8 compare off", hi, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(A_CTRL, 0);
    wr(A_RLD, 32'h1111_2222);
    wr(A_MAT, 32'h3333_4444);
    wr(A_CNT, 32'h5555_6666);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h424, 32'h0000_0003);
    wr(12'h02E, 32'hDEAD_BEEF);
    rd(A_RLD, d);  chk("R11 reload kept", d, 32'h1111_2222);
    rd(A_MAT, d);  chk("R11 match kept", d, 32'h3333_4444);
    rd(A_CNT, d);  chk("R11 count kept", d, 32'h5555_6666);
    rd(A_CTRL, d); chk("R11 ctrl kept", d, 0);
    rd(12'h030, d); chk("R11 read zero", d, 0);
    rd(12'h438, d); chk("R11 read zero alias", d, 0);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_edges();
    t_duty("R7 mid duty",        32'hFFFF_FFF0, 32'hFFFF_FFF8, 16, 7);
    t_duty("R7 match at reload", 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16, 15);
    t_duty("R7 longer period",   32'hFFFF_FFE0, 32'hFFFF_FFF0, 32, 15);
    t_duty("R6 match at max",    32'hFFFF_FFF0, 32'hFFFF_FFFF, 16, 0);
    t_duty("R9 match below",     32'hFFFF_FFF0, 32'h0000_0005, 16, 0);
    t_cmp_off();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule